// File: doc/BRIEF.md
# Partial Store Byte Sequencer

This block turns one unaligned partial store into the memory writes it needs. A request carries register data, an effective address and four control bits: left or right variant, word (32-bit) or doubleword (64-bit) size, byte order, and output form. The block works out how many bytes of the register reach memory, which register byte goes where, and in which direction the address walks. It then issues the writes on a valid/ready write port and pulses `done` once the last write has been taken.

Two output forms exist. The byte form emits one single-byte write per handshake. The beat form emits one write aligned to the 8-byte bus, carrying a byte-enable mask. Both forms cover the same set of memory bytes with the same values. A request is taken only while the block is idle. Fault handling and address translation belong to other blocks.

Top module: `pstore_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `wr_valid` and `done` are 0.
- R2: For a word store (`req_dword`=0), the lane index is `addr[1:0]` when `req_big`=1 and `3 - addr[1:0]` when `req_big`=0. A left store (`req_right`=0) writes 4 - lane bytes and a right store (`req_right`=1) writes lane + 1 bytes.
- R3: For a doubleword store (`req_dword`=1), the lane index is `addr[2:0]` when `req_big`=1 and `7 - addr[2:0]` otherwise. A left store writes 8 - lane bytes and a right store writes lane + 1 bytes.
- R4: In a left store, write number k (counting from 0) carries register byte S-1-k, where S is 4 or 8 and byte 0 is bits [7:0]. Writes go out in increasing k.
- R5: In a right store, write number k carries register byte k. Writes go out in increasing k.
- R6: Let step be +1 when `req_big`=1 and -1 when it is 0. Write k of a left store goes to addr + k*step, and write k of a right store goes to addr - k*step.
- R7: Each write is held on the port until `wr_ready` is 1. While `wr_valid`=1 and `wr_ready`=0, all write-port outputs stay unchanged into the next cycle.
- R8: `done` is high for exactly one cycle. That cycle directly follows the handshake of the request's last write, and each request produces exactly one such pulse.
- R9: `req_ready` is 1 only while idle. A request offered while busy is not taken and adds no writes.
- R10: In byte form (`req_mask`=0), `wr_beat`=0, `wr_be`=8'h01, `wr_data[7:0]` holds the byte and all other data bits are 0. In beat form (`req_mask`=1), exactly one write goes out with `wr_beat`=1 at addr with bits [2:0] cleared. For every byte address A that the byte form would write, that write sets `wr_be[A mod 8]` and places the byte at `wr_data[8*(A mod 8)+:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_data | input | DATA_W | Register value to store |
| req_addr | input | ADDR_W | Effective byte address |
| req_right | input | 1 | 1 = right variant, 0 = left variant |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_mask | input | 1 | 1 = one masked beat, 0 = byte writes |
| wr_valid | output | 1 | Write present |
| wr_ready | input | 1 | Write accepted by memory side |
| wr_addr | output | ADDR_W | Byte address, or beat-aligned address |
| wr_data | output | DATA_W | Byte in [7:0], or beat data |
| wr_be | output | DATA_W/8 | Byte enables |
| wr_beat | output | 1 | 1 = masked beat write |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench sweeps every low-address value for both sizes, both variants, both byte orders and both output forms. The edge lanes are the main target: a design that inverts the lane the wrong way, or miscounts by one, writes a full word where only one byte belongs, or the reverse. A reversed address step makes bytes land below the effective address instead of above it, and the bench reports this as an address mismatch. Random backpressure exercises the hold rule and the timing of `done`, and a request offered while the block is busy checks that no extra writes appear.

// File: rtl/pstore_pkg.sv
// Shared types for the partial store byte sequencer.
package pstore_pkg;
    // Sequencer states: idle, issuing single bytes, issuing one masked beat.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BYTES = 2'd1,
        SQ_BEAT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pstore_lane_calc.sv
// Lane index and byte count of one partial store.
// Assumes LW >= 2, so a word mask of 3 fits; the doubleword mask is all ones.
module pstore_lane_calc #(
    parameter int LW = 3
) (
    input  logic [LW-1:0] addr_lo,
    input  logic          dword,
    input  logic          big,
    input  logic          right,
    output logic [LW:0]   count
);
    logic [LW-1:0] size_m1;
    logic [LW-1:0] lane;

    // Lane from low address bits, inverted for little-endian; count from variant.
    always_comb begin
        size_m1 = dword ? {LW{1'b1}} : LW'(3);
        lane    = (addr_lo & size_m1) ^ (big ? '0 : size_m1);
        if (right) begin
            count = {1'b0, lane} + 1'b1;
        end else begin
            count = {1'b0, size_m1} - {1'b0, lane} + 1'b1;
        end
    end
endmodule

// File: rtl/pstore_byte_pick.sv
// Address and value of write number k within a partial store.
// Assumes k is below the store's byte count; does no range checking.
module pstore_byte_pick #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LW     = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] base,
    input  logic [LW-1:0]     k,
    input  logic              dword,
    input  logic              right,
    input  logic              big,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        val
);
    logic [LW-1:0] size_m1;
    logic [LW-1:0] idx;
    logic          walk_up;

    // Pick the register byte and walk the address up or down by k.
    always_comb begin
        size_m1 = dword ? {LW{1'b1}} : LW'(3);
        idx     = right ? k : (size_m1 - k);
        val     = data[{idx, 3'b000} +: 8];
        walk_up = big ^ right;
        addr    = walk_up ? (base + ADDR_W'(k)) : (base - ADDR_W'(k));
    end
endmodule

// File: rtl/pstore_beat_build.sv
// Builds the one aligned masked beat that covers a whole partial store.
// Assumes every byte of the store lies in one bus-aligned beat, which holds
// because a store never leaves its naturally aligned word or doubleword.
module pstore_beat_build #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LW     = 3
) (
    input  logic [DATA_W-1:0]   data,
    input  logic [ADDR_W-1:0]   base,
    input  logic [LW:0]         count,
    input  logic                dword,
    input  logic                right,
    input  logic                big,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   beat
);
    localparam int NB = DATA_W / 8;

    logic [ADDR_W-1:0] slot_addr [NB];
    logic [7:0]        slot_val  [NB];

    for (genvar g = 0; g < NB; g++) begin : g_slot
        pstore_byte_pick #(
            .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LW(LW)
        ) u_pick (
            .data (data),
            .base (base),
            .k    (LW'(g)),
            .dword(dword),
            .right(right),
            .big  (big),
            .addr (slot_addr[g]),
            .val  (slot_val[g])
        );
    end

    // Scatter each live byte into its bus lane and raise its enable.
    always_comb begin
        be   = '0;
        beat = '0;
        for (int i = 0; i < NB; i++) begin
            if ((LW+1)'(i) < count) begin
                be[slot_addr[i][LW-1:0]]                 = 1'b1;
                beat[{slot_addr[i][LW-1:0], 3'b000} +: 8] = slot_val[i];
            end
        end
    end
endmodule

// File: rtl/pstore_seq.sv
// Partial store byte sequencer top.
// Takes one left/right, word/doubleword store while idle and issues it either
// as a run of single-byte writes or as one masked beat. A done pulse follows
// the last accepted write. Assumes DATA_W is 64 (beat width = doubleword).
module pstore_seq #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [DATA_W-1:0]   req_data,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_right,
    input  logic                req_dword,
    input  logic                req_big,
    input  logic                req_mask,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_be,
    output logic                wr_beat,
    output logic                done
);
    import pstore_pkg::*;

    localparam int NB = DATA_W / 8;
    localparam int LW = $clog2(NB);

    seq_state_t        state_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;
    logic              right_q, dword_q, big_q;
    logic [LW:0]       cnt_q;
    logic [LW-1:0]     k_q;
    logic              done_q;

    logic [LW:0]       req_count;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        byte_val;
    logic [NB-1:0]     beat_be;
    logic [DATA_W-1:0] beat_data;
    logic              take_req;
    logic              take_wr;
    logic              last_byte;

    pstore_lane_calc #(.LW(LW)) u_lane (
        .addr_lo(req_addr[LW-1:0]),
        .dword  (req_dword),
        .big    (req_big),
        .right  (req_right),
        .count  (req_count)
    );

    pstore_byte_pick #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LW(LW)
    ) u_cur (
        .data (data_q),
        .base (addr_q),
        .k    (k_q),
        .dword(dword_q),
        .right(right_q),
        .big  (big_q),
        .addr (byte_addr),
        .val  (byte_val)
    );

    pstore_beat_build #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LW(LW)
    ) u_beat (
        .data (data_q),
        .base (addr_q),
        .count(cnt_q),
        .dword(dword_q),
        .right(right_q),
        .big  (big_q),
        .be   (beat_be),
        .beat (beat_data)
    );

    // Handshake qualifiers and end-of-run detection.
    always_comb begin
        req_ready = (state_q == SQ_IDLE);
        wr_valid  = (state_q != SQ_IDLE);
        take_req  = req_valid && req_ready;
        take_wr   = wr_valid && wr_ready;
        last_byte = ({1'b0, k_q} == (cnt_q - 1'b1));
    end

    // Write-port payload for the current state.
    always_comb begin
        wr_beat = (state_q == SQ_BEAT);
        if (state_q == SQ_BEAT) begin
            wr_addr = {addr_q[ADDR_W-1:LW], {LW{1'b0}}};
            wr_data = beat_data;
            wr_be   = beat_be;
        end else begin
            wr_addr = byte_addr;
            wr_data = {{(DATA_W-8){1'b0}}, byte_val};
            wr_be   = NB'(1);
        end
        done = done_q;
    end

    // Sequencer state, request capture and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            data_q  <= '0;
            addr_q  <= '0;
            right_q <= 1'b0;
            dword_q <= 1'b0;
            big_q   <= 1'b0;
            cnt_q   <= '0;
            k_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (take_req) begin
                        data_q  <= req_data;
                        addr_q  <= req_addr;
                        right_q <= req_right;
                        dword_q <= req_dword;
                        big_q   <= req_big;
                        cnt_q   <= req_count;
                        k_q     <= '0;
                        state_q <= req_mask ? SQ_BEAT : SQ_BYTES;
                    end
                end
                SQ_BYTES: begin
                    if (take_wr) begin
                        if (last_byte) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            k_q <= k_q + 1'b1;
                        end
                    end
                end
                SQ_BEAT: begin
                    if (take_wr) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pstore_seq_chk.sv
// Port-level protocol checks for pstore_seq, bound to every instance.
// Assumes the port names of pstore_seq.
module pstore_seq_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [DATA_W-1:0]   req_data,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                req_right,
    input logic                req_dword,
    input logic                req_big,
    input logic                req_mask,
    input logic                wr_valid,
    input logic                wr_ready,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W/8-1:0] wr_be,
    input logic                wr_beat,
    input logic                done
);
    localparam int LW = $clog2(DATA_W / 8);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !wr_valid && !done));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_be) && $stable(wr_beat)));

    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ready));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wr_valid);

    p_beat_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_beat) |-> (wr_addr[LW-1:0] == '0 && wr_be != '0));

    p_byte_form_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_beat) |-> (wr_be == (DATA_W/8)'(1) && wr_data[DATA_W-1:8] == '0));
endmodule

bind pstore_seq pstore_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pstore_seq.sv
// Bench for pstore_seq: behavioural queue model compared every clock.
module sim_pstore_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_data = '0;
    logic [31:0] req_addr = '0;
    logic        req_right = 1'b0, req_dword = 1'b0, req_big = 1'b0, req_mask = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;
    logic        wr_beat;
    logic        done;

    pstore_seq u0 (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] a;
        logic [63:0] d;
        logic [7:0]  be;
        bit          beat;
        bit          last;
        string       tag;
    } exp_t;

    exp_t  q[$];
    int    n_q[$];
    string nt_q[$];
    int    total = 0, bad = 0;
    int    wcount = 0;
    bit    exp_done = 0;
    bit    hold_ready = 0;
    bit    mon_on = 0;
    bit    prev_stall = 0;
    logic [31:0] p_a; logic [63:0] p_d; logic [7:0] p_be; logic p_beat;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model of the requirements: expected writes of one accepted request.
    task automatic model_req(logic [63:0] d, logic [31:0] a, bit r, bit dw, bit bg, bit m);
        int s, lane, n, idx, step;
        logic [7:0]  v, be;
        logic [31:0] ba;
        logic [63:0] bd;
        exp_t e;
        s = dw ? 8 : 4;
        lane = int'(a[2:0]) % s;
        if (!bg) lane = s - 1 - lane;
        n = r ? lane + 1 : s - lane;
        step = bg ? 1 : -1;
        be = '0; bd = '0;
        for (int k = 0; k < n; k++) begin
            idx = r ? k : s - 1 - k;
            v = d[8*idx +: 8];
            ba = r ? a - 32'(k*step) : a + 32'(k*step);
            if (m) begin
                be[ba[2:0]] = 1'b1;
                bd[8*ba[2:0] +: 8] = v;
            end else begin
                e.a = ba; e.d = {56'b0, v}; e.be = 8'h01; e.beat = 0;
                e.last = (k == n - 1); e.tag = r ? "R5" : "R4";
                q.push_back(e);
            end
        end
        if (m) begin
            e.a = {a[31:3], 3'b000}; e.d = bd; e.be = be; e.beat = 1;
            e.last = 1; e.tag = "R10";
            q.push_back(e);
        end
        n_q.push_back(m ? 1 : n);
        nt_q.push_back(m ? "R10" : (dw ? "R3" : "R2"));
    endtask

    // Ready pattern: random backpressure unless held low.
    always @(posedge clk) begin
        #1 wr_ready = hold_ready ? 1'b0 : ($urandom_range(0, 3) != 0);
    end

    // Monitor: compare outputs with the model away from the clock edge.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            exp_t e;
            chk(done == exp_done, "R8", "done", 64'(done), 64'(exp_done));
            if (done) begin
                if (n_q.size() != 0) begin
                    chk(wcount == n_q[0], nt_q[0], "write count", 64'(wcount), 64'(n_q[0]));
                    void'(n_q.pop_front()); void'(nt_q.pop_front());
                end
                wcount = 0;
            end
            exp_done = 0;
            if (prev_stall)
                chk(wr_valid && wr_addr == p_a && wr_data == p_d && wr_be == p_be && wr_beat == p_beat,
                    "R7", "held write", wr_data, p_d);
            if (wr_valid && wr_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected write", 64'(wr_addr), 64'(0));
                end else begin
                    e = q.pop_front();
                    chk(wr_addr == e.a, (e.tag == "R10") ? "R10" : "R6", "addr", 64'(wr_addr), 64'(e.a));
                    chk(wr_data == e.d && wr_be == e.be && wr_beat == e.beat, e.tag, "data",
                        wr_data, e.d);
                    wcount++;
                    if (e.last) exp_done = 1;
                end
            end
            prev_stall = wr_valid && !wr_ready;
            p_a = wr_addr; p_d = wr_data; p_be = wr_be; p_beat = wr_beat;
            if (req_valid && req_ready)
                model_req(req_data, req_addr, req_right, req_dword, req_big, req_mask);
        end
    end

    task automatic send(logic [63:0] d, logic [31:0] a, bit r, bit dw, bit bg, bit m);
        @(posedge clk); #1;
        req_valid = 1; req_data = d; req_addr = a;
        req_right = r; req_dword = dw; req_big = bg; req_mask = m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic drain();
        while (q.size() != 0 || n_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !wr_valid && !done, "R1", "during reset",
            {61'b0, req_ready, wr_valid, done}, 64'h4);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(req_ready && !wr_valid && !done, "R1", "after reset",
            {61'b0, req_ready, wr_valid, done}, 64'h4);
        mon_on = 1;

        // R2 R3 R4 R5 R6 R10: every lane, size, variant, order and form.
        for (int m = 0; m < 2; m++)
            for (int dw = 0; dw < 2; dw++)
                for (int r = 0; r < 2; r++)
                    for (int bg = 0; bg < 2; bg++)
                        for (int lo = 0; lo < 8; lo++) begin
                            send(64'h8877665544332211 ^ {8{8'(lo)}}, 32'h0000_1230 + 32'(lo),
                                 r[0], dw[0], bg[0], m[0]);
                            drain();
                        end

        // R9: request offered while busy is not taken.
        hold_ready = 1;
        send(64'hA1A2A3A4A5A6A7A8, 32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b0);
        @(posedge clk); #1;
        req_valid = 1; req_data = 64'hDEADBEEFDEADBEEF; req_addr = 32'h0000_3005;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req_ready, "R9", "ready while busy", 64'(req_ready), 64'(0));
        end
        @(posedge clk); #1 req_valid = 0;
        hold_ready = 0;
        drain();

        // Random mix under random backpressure.
        for (int i = 0; i < 80; i++) begin
            send({$urandom, $urandom}, $urandom, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 1) != 0) drain();
        end
        drain();

        chk(q.size() == 0 && n_q.size() == 0, "R8", "model empty", 64'(q.size()), 64'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule